// File: doc/BRIEF.md
# Cluster Power-Down Sequencer

This block steps a multi-core processor cluster through an orderly shutdown. A single request starts the sequence. It first waits until every core other than the lead core reports shutdown. If an accelerator coherency port is present, it waits until the attached master has stopped and then raises the port's inactive request; without that port, this step is skipped. It then waits for software to report that the L2 cache has been cleaned and invalidated, and raises the snoop-inactive request of the selected coherency protocol.

Next it waits for the L2 memory system to report idle. It then enables the isolation clamps and, one cycle later, switches off the cluster-top and L2 power domains together. The cache maintenance, the per-core shutdown and the analog switches themselves sit outside the block. They appear here only as handshake inputs and outputs.

Each wait phase is guarded by a timeout that software can set. On expiry the sequencer flags an error, stays where it stopped and keeps power on. After reaching the final phase, the block stays there until reset.

Top module: `cluster_pdn_seq`

## Requirements
- R1: After reset, `phase` is 0 (running) and `tmo_err`, `acp_inact`, `ace_snp_inact`, `chi_snp_inact`, `clamp_en`, `pwr_off_top` and `pwr_off_l2` are all 0.
- R2: A high `pdn_req` in phase 0 moves the block to phase 1 on the next clock. The block leaves phase 1 only when every bit of `core_down` is 1.
- R3: With `acp_present`=1, phase 1 is followed by phase 2. There the block waits for `acp_master_idle`, then raises `acp_inact` as it enters phase 3. With `acp_present`=0, phase 1 goes straight to phase 3 and `acp_inact` stays 0.
- R4: No snoop-inactive output rises before `flush_done` is seen high in phase 3. On the clock that samples it, the block enters phase 4 and the snoop-inactive output rises.
- R5: `proto_chi` is sampled when the request is accepted. A value of 0 selects `ace_snp_inact` and a value of 1 selects `chi_snp_inact`. At most one of the two is ever high.
- R6: The block stays in phase 4 until `l2_idle` is high. On the clock that samples it, the block enters phase 5 (clamp) and `clamp_en` rises.
- R7: Exactly one clock after phase 5 is entered, the block enters phase 6 (off) and `pwr_off_top` and `pwr_off_l2` rise together. Neither is ever high while `clamp_en` is low.
- R8: In phase 6, `pdn_req` and every handshake input are ignored and all outputs hold until reset.
- R9: When `tmo_limit` is nonzero and a wait phase (1 to 4) lasts that many cycles without its condition, `tmo_err` rises. The phase then freezes, later handshakes are ignored and both power-off outputs stay 0. A `tmo_limit` of 0 disables the timeout.
- R10: Once high, `acp_inact`, the snoop-inactive outputs, `clamp_en` and the power-off outputs stay high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pdn_req | input | 1 | Power-down request |
| core_down | input | NUM_CORES-1 | Shutdown status of each non-lead core |
| acp_present | input | 1 | Coherency port built in |
| acp_master_idle | input | 1 | Port master has stopped issuing transactions |
| proto_chi | input | 1 | 0: ACE interface, 1: CHI interface |
| flush_done | input | 1 | L2 clean-and-invalidate complete |
| l2_idle | input | 1 | L2 memory system standby |
| tmo_limit | input | TMO_W | Timeout per wait phase in cycles, 0 disables |
| acp_inact | output | 1 | Coherency-port inactive request |
| ace_snp_inact | output | 1 | ACE snoop-inactive request |
| chi_snp_inact | output | 1 | CHI snoop-inactive request |
| clamp_en | output | 1 | Cluster isolation clamp enable |
| pwr_off_top | output | 1 | Cluster-top domain power-off |
| pwr_off_l2 | output | 1 | L2 domain power-off |
| phase | output | 3 | Current phase, 0 to 6 |
| tmo_err | output | 1 | Wait-phase timeout error |

## Verification
The assertions assume that `acp_present` and `proto_chi` are static configuration, holding steady from reset through the whole sequence. In particular, the check that ties `acp_inact` to `acp_present` relies on the port flag not changing mid-run. The stimulus therefore sets both flags only while reset is held and never changes them until the next reset. All handshake inputs are driven on the falling clock edge. In each scenario, `tmo_limit` is either 0 or large relative to the delays before each handshake, except in the one scenario that is meant to reach a timeout.

// File: rtl/pdn_pkg.sv
package pdn_pkg;

    typedef enum logic [2:0] {
        PH_RUN   = 3'd0,
        PH_CORES = 3'd1,
        PH_ACP   = 3'd2,
        PH_FLUSH = 3'd3,
        PH_IDLE  = 3'd4,
        PH_CLAMP = 3'd5,
        PH_OFF   = 3'd6
    } pdn_phase_e;

    typedef struct packed {
        pdn_phase_e phase;
        logic       err;
        logic       acp_inact;
        logic       snp_req;
        logic       use_chi;
        logic       clamp;
        logic       pwr_off;
    } pdn_state_t;

endpackage

// File: rtl/pdn_wait_timer.sv
module pdn_wait_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         active,
    input  logic         restart,
    input  logic [W-1:0] limit,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    assign expired = active && (limit != '0) && (cnt_q == limit);

    always_comb begin
        cnt_d = cnt_q;
        if (restart || !active) begin
            cnt_d = '0;
        end else if (!expired) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/pdn_snoop_sel.sv
module pdn_snoop_sel (
    input  logic req,
    input  logic use_chi,
    output logic ace_inact,
    output logic chi_inact
);
    // Only the interface chosen at request time ever sees the request.
    assign ace_inact = req && !use_chi;
    assign chi_inact = req &&  use_chi;
endmodule

// File: rtl/cluster_pdn_seq.sv
module cluster_pdn_seq #(
    parameter int NUM_CORES = 4,
    parameter int TMO_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pdn_req,
    input  logic [NUM_CORES-2:0] core_down,
    input  logic             acp_present,
    input  logic             acp_master_idle,
    input  logic             proto_chi,
    input  logic             flush_done,
    input  logic             l2_idle,
    input  logic [TMO_W-1:0] tmo_limit,
    output logic             acp_inact,
    output logic             ace_snp_inact,
    output logic             chi_snp_inact,
    output logic             clamp_en,
    output logic             pwr_off_top,
    output logic             pwr_off_l2,
    output logic [2:0]       phase,
    output logic             tmo_err
);
    import pdn_pkg::*;

    localparam int NON_LEAD = NUM_CORES - 1;

    pdn_state_t s_d, s_q;
    logic       others_down;
    logic       in_wait;
    logic       restart;
    logic       expired;

    assign others_down = (core_down == {NON_LEAD{1'b1}});
    assign in_wait = (s_q.phase == PH_CORES) || (s_q.phase == PH_ACP) ||
                     (s_q.phase == PH_FLUSH) || (s_q.phase == PH_IDLE);

    always_comb begin
        s_d = s_q;
        if (!s_q.err) begin
            unique case (s_q.phase)
                PH_RUN: begin
                    if (pdn_req) begin
                        s_d.phase   = PH_CORES;
                        s_d.use_chi = proto_chi;
                    end
                end
                PH_CORES: begin
                    if (others_down) begin
                        s_d.phase = acp_present ? PH_ACP : PH_FLUSH;
                    end
                end
                PH_ACP: begin
                    if (acp_master_idle) begin
                        s_d.acp_inact = 1'b1;
                        s_d.phase     = PH_FLUSH;
                    end
                end
                PH_FLUSH: begin
                    if (flush_done) begin
                        s_d.snp_req = 1'b1;
                        s_d.phase   = PH_IDLE;
                    end
                end
                PH_IDLE: begin
                    if (l2_idle) begin
                        s_d.clamp = 1'b1;
                        s_d.phase = PH_CLAMP;
                    end
                end
                PH_CLAMP: begin
                    // Clamps settle for one cycle before the switches open.
                    s_d.pwr_off = 1'b1;
                    s_d.phase   = PH_OFF;
                end
                default: begin
                    s_d = s_q;
                end
            endcase
            if (expired && (s_d.phase == s_q.phase)) begin
                s_d.err = 1'b1;
            end
        end
    end

    assign restart = (s_d.phase != s_q.phase);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_RUN, default: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    pdn_wait_timer #(.W(TMO_W)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (in_wait && !s_q.err),
        .restart (restart),
        .limit   (tmo_limit),
        .expired (expired)
    );

    pdn_snoop_sel i_snoop (
        .req       (s_q.snp_req),
        .use_chi   (s_q.use_chi),
        .ace_inact (ace_snp_inact),
        .chi_inact (chi_snp_inact)
    );

    assign acp_inact   = s_q.acp_inact;
    assign clamp_en    = s_q.clamp;
    assign pwr_off_top = s_q.pwr_off;
    assign pwr_off_l2  = s_q.pwr_off;
    assign phase       = s_q.phase;
    assign tmo_err     = s_q.err;
endmodule

// File: rtl/pdn_seq_checker.sv
module pdn_seq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       acp_present,
    input logic [2:0] phase,
    input logic       tmo_err,
    input logic       acp_inact,
    input logic       ace_snp_inact,
    input logic       chi_snp_inact,
    input logic       clamp_en,
    input logic       pwr_off_top,
    input logic       pwr_off_l2
);
    assert_pwr_needs_clamp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_off_top || pwr_off_l2) |-> clamp_en);

    assert_pwr_after_clamp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_off_top) |-> $past(clamp_en));

    assert_snoop_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ace_snp_inact, chi_snp_inact}));

    assert_clamp_after_snoop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clamp_en |-> (ace_snp_inact || chi_snp_inact));

    assert_acp_only_present_R3: assert property (@(posedge clk) disable iff (!rst_n)
        acp_inact |-> acp_present);

    assert_err_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_err |=> ($stable(phase) && tmo_err && !pwr_off_top));

    assert_off_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd6) |=> (phase == 3'd6));

    assert_clamp_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clamp_en |=> clamp_en);
endmodule

bind cluster_pdn_seq pdn_seq_checker i_pdn_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .acp_present   (acp_present),
    .phase         (phase),
    .tmo_err       (tmo_err),
    .acp_inact     (acp_inact),
    .ace_snp_inact (ace_snp_inact),
    .chi_snp_inact (chi_snp_inact),
    .clamp_en      (clamp_en),
    .pwr_off_top   (pwr_off_top),
    .pwr_off_l2    (pwr_off_l2)
);

// File: tb/test_cluster_pdn_seq.sv
`timescale 1ns/1ps
module test_cluster_pdn_seq;
    localparam int NUM_CORES = 4;
    localparam int TMO_W     = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pdn_req = 1'b0;
    logic [NUM_CORES-2:0] core_down = '0;
    logic acp_present = 1'b0;
    logic acp_master_idle = 1'b0;
    logic proto_chi = 1'b0;
    logic flush_done = 1'b0;
    logic l2_idle = 1'b0;
    logic [TMO_W-1:0] tmo_limit = '0;
    logic acp_inact, ace_snp_inact, chi_snp_inact, clamp_en;
    logic pwr_off_top, pwr_off_l2, tmo_err;
    logic [2:0] phase;

    int checks = 0;
    int errors = 0;
    logic [9:0] exp_q[$];
    string      tag_q[$];
    logic [9:0] prev_snap = '0;

    always #2.5 clk = ~clk;

    cluster_pdn_seq #(.NUM_CORES(NUM_CORES), .TMO_W(TMO_W)) i_cluster_pdn_seq (
        .clk(clk), .rst_n(rst_n), .pdn_req(pdn_req), .core_down(core_down),
        .acp_present(acp_present), .acp_master_idle(acp_master_idle),
        .proto_chi(proto_chi), .flush_done(flush_done), .l2_idle(l2_idle),
        .tmo_limit(tmo_limit), .acp_inact(acp_inact),
        .ace_snp_inact(ace_snp_inact), .chi_snp_inact(chi_snp_inact),
        .clamp_en(clamp_en), .pwr_off_top(pwr_off_top), .pwr_off_l2(pwr_off_l2),
        .phase(phase), .tmo_err(tmo_err)
    );

    function automatic logic [9:0] snap();
        return {phase, tmo_err, acp_inact, ace_snp_inact, chi_snp_inact,
                clamp_en, pwr_off_top, pwr_off_l2};
    endfunction

    function automatic logic [9:0] mk(input logic [2:0] ph, input logic err,
                                      input logic acp, input logic ace,
                                      input logic chi, input logic clp,
                                      input logic pw);
        return {ph, err, acp, ace, chi, clp, pw, pw};
    endfunction

    task automatic check(input logic ok, input string tag,
                         input logic [9:0] act, input logic [9:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic push(input logic [9:0] v, input string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    // Monitor: every change of the observed output vector must match the next expected item.
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_snap = '0;
        end else if (snap() != prev_snap) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "unexpected output change (R8/R10)", snap(), prev_snap);
            end else begin
                logic [9:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(snap() == e, t, snap(), e);
            end
            prev_snap = snap();
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic acp, input logic chi, input logic [TMO_W-1:0] lim);
        @(negedge clk);
        rst_n = 1'b0;
        pdn_req = 0; core_down = '0; acp_master_idle = 0;
        flush_done = 0; l2_idle = 0;
        acp_present = acp; proto_chi = chi; tmo_limit = lim;
        cycles(3);
        rst_n = 1'b1;
        cycles(1);
        check(snap() == '0, "R1 reset state", snap(), '0);
    endtask

    // Driver: queue the expected order, then drive the handshakes with gaps.
    task automatic run_seq(input logic acp, input logic chi, input int gap);
        logic a, c;
        a = !chi; c = chi;
        push(mk(3'd1, 0, 0, 0, 0, 0, 0), "R2 enter core wait");
        if (acp) begin
            push(mk(3'd2, 0, 0, 0, 0, 0, 0), "R3 enter port wait");
            push(mk(3'd3, 0, 1, 0, 0, 0, 0), "R3 port inactive raised");
        end else begin
            push(mk(3'd3, 0, 0, 0, 0, 0, 0), "R3 port step skipped");
        end
        push(mk(3'd4, 0, acp, a, c, 0, 0), "R4/R5 snoop inactive");
        push(mk(3'd5, 0, acp, a, c, 1, 0), "R6 clamp");
        push(mk(3'd6, 0, acp, a, c, 1, 1), "R7 power off");

        pdn_req = 1; cycles(1); pdn_req = 0;
        // only part of the cores down: must hold in phase 1
        core_down = 3'b011; cycles(gap);
        check(phase == 3'd1, "R2 holds while a core is up", {7'd0, phase}, 10'd1);
        core_down = 3'b111; cycles(gap);
        if (acp) begin
            check(!acp_inact, "R3 no port request before master stops",
                  {9'd0, acp_inact}, '0);
            acp_master_idle = 1; cycles(gap);
        end
        check(!ace_snp_inact && !chi_snp_inact, "R4 no snoop request before flush",
              {8'd0, ace_snp_inact, chi_snp_inact}, '0);
        flush_done = 1; cycles(1); flush_done = 0;
        cycles(gap);
        check(!clamp_en, "R6 no clamp before L2 idle", {9'd0, clamp_en}, '0);
        l2_idle = 1; cycles(1);
        check(clamp_en && !pwr_off_top, "R7 clamp one cycle before power",
              snap(), mk(3'd5, 0, acp, a, c, 1, 0));
        cycles(1);
        check(pwr_off_top && pwr_off_l2, "R7 both domains off", snap(),
              mk(3'd6, 0, acp, a, c, 1, 1));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        // ACE, port present, timeout disabled with long gaps
        do_reset(1, 0, '0);
        run_seq(1, 0, 40);
        // R8: in off phase, everything is ignored
        pdn_req = 1; flush_done = 1; l2_idle = 0; core_down = '0; cycles(10);
        pdn_req = 0; flush_done = 0;
        check(snap() == mk(3'd6, 0, 1, 1, 0, 1, 1), "R8 off phase holds", snap(),
              mk(3'd6, 0, 1, 1, 0, 1, 1));

        // CHI, port present
        do_reset(1, 1, 16'd200);
        run_seq(1, 1, 5);
        // ACE, port absent
        do_reset(0, 0, 16'd200);
        run_seq(0, 0, 5);
        // CHI, port absent
        do_reset(0, 1, '0);
        run_seq(0, 1, 3);

        // R9: timeout in the core wait
        do_reset(0, 0, 16'd8);
        push(mk(3'd1, 0, 0, 0, 0, 0, 0), "R9 enter core wait");
        push(mk(3'd1, 1, 0, 0, 0, 0, 0), "R9 timeout flagged");
        pdn_req = 1; cycles(1); pdn_req = 0;
        cycles(20);
        check(tmo_err && phase == 3'd1, "R9 error set in phase 1", snap(),
              mk(3'd1, 1, 0, 0, 0, 0, 0));
        core_down = 3'b111; flush_done = 1; l2_idle = 1; cycles(10);
        check(snap() == mk(3'd1, 1, 0, 0, 0, 0, 0), "R9 frozen and powered",
              snap(), mk(3'd1, 1, 0, 0, 0, 0, 0));
        flush_done = 0; l2_idle = 0;

        cycles(2);
        check(exp_q.size() == 0, "R10 all expected transitions seen",
              10'(exp_q.size()), '0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule